// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block sits between instruction decode and issue. It accepts one decoded three-operand scalar instruction (one destination and two sources) and expands it into a series of element operations. Each operand carries a vector tag. If the tag is set, that operand's register number advances by one for each element. If the tag is clear, the operand stays on its base register. One opcode therefore acts as a vector, mixed scalar-vector or plain scalar operation, with no separate vector opcodes.

A start pulse captures the vector length, the three base register numbers, the tags and an optional predicate mask. The sequencer then walks element numbers upward from zero. Elements whose predicate bit is clear are skipped. Each remaining element is offered on a valid/ready issue port. A scalar destination ends the walk after its first issued element. The busy output holds off program-counter advance until the walk has finished and the one-cycle done pulse has been given.

Top module: `vec_elem_seq`

## Requirements
- R1: After synchronous reset, busy_o, issue_valid_o, done_o and err_o are all low.
- R2: A start pulse is accepted only while busy_o is low and captures every request input. While busy_o is high, start_i and the request inputs have no effect on the running sequence.
- R3: Issued elements appear in strictly ascending element order between 0 and VL-1, and elem_o gives the current element number.
- R4: For each operand, the issued register index is base plus the element number when its vector tag is 1, and equals the base for every element when the tag is 0.
- R5: Bit i of pred_mask_i (bit 0 belongs to element 0) set to 0 skips element i, with no issue. When pred_en_i is 0, the mask is ignored and treated as all ones.
- R6: With a scalar destination (rt_vec_i = 0), the sequence ends after the first issued element. Later elements are never issued.
- R7: While issue_valid_o is high and issue_ready_i is low, issue_valid_o stays high and all indices and elem_o stay unchanged in the next cycle.
- R8: busy_o is high from the cycle after an accepted start through the done cycle, and low otherwise.
- R9: done_o is a single-cycle pulse at completion. It is given even when no element is issued (VL = 0 or every bit masked).
- R10: A request with VL above 64, or with a vector-tagged operand whose base + VL - 1 exceeds 127, issues no element. It completes with err_o and done_o high together. A vector operand reaching exactly register 127 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| vl_i | input | 7 | Vector length, 0 to 64 legal |
| rt_base_i | input | 7 | Destination base register |
| ra_base_i | input | 7 | First source base register |
| rb_base_i | input | 7 | Second source base register |
| rt_vec_i | input | 1 | Destination vector tag |
| ra_vec_i | input | 1 | First source vector tag |
| rb_vec_i | input | 1 | Second source vector tag |
| pred_en_i | input | 1 | Predicate mask enable |
| pred_mask_i | input | 64 | Predicate mask, bit i for element i |
| issue_ready_i | input | 1 | Issue stage accepts the offered element |
| issue_valid_o | output | 1 | Element operation offered |
| elem_o | output | 6 | Element number of the offered operation |
| rd_idx_o | output | 7 | Destination register index |
| rs1_idx_o | output | 7 | First source register index |
| rs2_idx_o | output | 7 | Second source register index |
| busy_o | output | 1 | Program-counter stall |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Range error, given with done_o |

## Verification
Two activities can fall in the same cycle. One is predicate skipping, which advances the element counter on its own. The other is the issue handshake, which advances it only on ready. A stalled element must not be skipped past, and a masked element must never be offered. Random masks combined with random ready gaps create cycles where a stalled offer is followed directly by masked elements. The bench judges each offered element against a list precomputed from the mask, the length and the destination tag. It also requires indices to stay unchanged across every stall.

A second collision is a start pulse that arrives mid-sequence. The bench drives one with different operands and checks that the running sequence continues unchanged.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int MAX_VL   = 64;
    localparam int REG_W    = 7;
    localparam int NUM_OPS  = 3;
    localparam int VL_W     = $clog2(MAX_VL + 1);
    localparam int ELEM_W   = $clog2(MAX_VL);
    localparam int NUM_REGS = 1 << REG_W;
    localparam int OP_DST   = 0;
    localparam int OP_SA    = 1;
    localparam int OP_SB    = 2;

    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [VL_W-1:0]   vl_t;
    typedef logic [ELEM_W-1:0] elem_t;
    typedef logic [MAX_VL-1:0] pmask_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        reg_idx_t base;
        logic     is_vec;
    } opnd_t;

    function automatic logic span_overflows(opnd_t op, vl_t vl);
        int last;
        if (!op.is_vec || vl == '0) return 1'b0;
        last = int'(op.base) + int'(vl) - 1;
        return last > (NUM_REGS - 1);
    endfunction
endpackage

// File: rtl/vseq_range_chk.sv
module vseq_range_chk
    import vseq_pkg::*;
(
    input  opnd_t [NUM_OPS-1:0] ops_i,
    input  vl_t                 vl_i,
    output logic                err_o
);
    logic [NUM_OPS-1:0] op_bad;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        assign op_bad[g] = span_overflows(ops_i[g], vl_i);
    end

    assign err_o = (|op_bad) || (int'(vl_i) > MAX_VL);
endmodule

// File: rtl/vseq_index_gen.sv
module vseq_index_gen
    import vseq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_i,
    input  logic                   busy_i,
    input  opnd_t    [NUM_OPS-1:0] ops_i,
    input  elem_t                  elem_i,
    output reg_idx_t [NUM_OPS-1:0] idx_o
);
    opnd_t [NUM_OPS-1:0] ops_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ops_q <= '0;
        end else if (load_i) begin
            ops_q <= ops_i;
        end
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_idx
        assign idx_o[g] = ops_q[g].base + (ops_q[g].is_vec ? reg_idx_t'(elem_i) : reg_idx_t'(0));

        AST_SCALAR_FIXED: assert property (@(posedge clk) disable iff (rst)
            busy_i && $past(busy_i) && !ops_q[g].is_vec |-> $stable(idx_o[g])); // R4
    end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  vl_t    vl_i,
    input  logic   pred_en_i,
    input  pmask_t pred_mask_i,
    input  logic   dst_vec_i,
    input  logic   range_err_i,
    input  logic   ready_i,
    output logic   load_o,
    output logic   valid_o,
    output elem_t  elem_o,
    output logic   busy_o,
    output logic   done_o,
    output logic   err_o
);
    seq_state_e state_q;
    vl_t        vl_q;
    vl_t        elem_q;
    pmask_t     mask_q;
    logic       dvec_q;
    logic       err_q;
    logic       in_range;
    logic       bit_on;

    assign load_o   = (state_q == ST_IDLE) && start_i;
    assign in_range = elem_q < vl_q;
    assign bit_on   = mask_q[elem_q[ELEM_W-1:0]];
    assign valid_o  = (state_q == ST_RUN) && in_range && bit_on;
    assign elem_o   = elem_q[ELEM_W-1:0];
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DONE);
    assign err_o    = done_o && err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vl_q    <= '0;
            elem_q  <= '0;
            mask_q  <= '0;
            dvec_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        vl_q    <= vl_i;
                        mask_q  <= pred_en_i ? pred_mask_i : '1;
                        dvec_q  <= dst_vec_i;
                        err_q   <= range_err_i;
                        elem_q  <= '0;
                        state_q <= range_err_i ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!in_range) begin
                        state_q <= ST_DONE;
                    end else if (!bit_on) begin
                        elem_q <= elem_q + 1'b1;
                    end else if (ready_i) begin
                        if (!dvec_q) state_q <= ST_DONE;
                        else         elem_q  <= elem_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    err_q   <= 1'b0;
                end
            endcase
        end
    end

    AST_SCALAR_DST_END: assert property (@(posedge clk) disable iff (rst)
        valid_o && ready_i && !dvec_q |=> done_o && !valid_o); // R6
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [6:0]  vl_i,
    input  logic [6:0]  rt_base_i,
    input  logic [6:0]  ra_base_i,
    input  logic [6:0]  rb_base_i,
    input  logic        rt_vec_i,
    input  logic        ra_vec_i,
    input  logic        rb_vec_i,
    input  logic        pred_en_i,
    input  logic [63:0] pred_mask_i,
    input  logic        issue_ready_i,
    output logic        issue_valid_o,
    output logic [5:0]  elem_o,
    output logic [6:0]  rd_idx_o,
    output logic [6:0]  rs1_idx_o,
    output logic [6:0]  rs2_idx_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o
);
    opnd_t    [NUM_OPS-1:0] req_ops;
    reg_idx_t [NUM_OPS-1:0] idx;
    logic                   range_err;
    logic                   load;

    assign req_ops[OP_DST] = '{base: rt_base_i, is_vec: rt_vec_i};
    assign req_ops[OP_SA]  = '{base: ra_base_i, is_vec: ra_vec_i};
    assign req_ops[OP_SB]  = '{base: rb_base_i, is_vec: rb_vec_i};

    vseq_range_chk u_range (
        .ops_i (req_ops),
        .vl_i  (vl_i),
        .err_o (range_err)
    );

    vseq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .vl_i        (vl_i),
        .pred_en_i   (pred_en_i),
        .pred_mask_i (pred_mask_i),
        .dst_vec_i   (rt_vec_i),
        .range_err_i (range_err),
        .ready_i     (issue_ready_i),
        .load_o      (load),
        .valid_o     (issue_valid_o),
        .elem_o      (elem_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    vseq_index_gen u_idx (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .busy_i (busy_o),
        .ops_i  (req_ops),
        .elem_i (elem_o),
        .idx_o  (idx)
    );

    assign rd_idx_o  = idx[OP_DST];
    assign rs1_idx_o = idx[OP_SA];
    assign rs2_idx_o = idx[OP_SB];

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        issue_valid_o && !issue_ready_i |=> issue_valid_o && $stable(elem_o)
            && $stable(rd_idx_o) && $stable(rs1_idx_o) && $stable(rs2_idx_o)); // R7

    AST_ELEM_ASCEND: assert property (@(posedge clk) disable iff (rst)
        $past(issue_valid_o && issue_ready_i) && $past(busy_o) && issue_valid_o
            |-> elem_o > $past(elem_o)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o); // R9

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o && !$past(issue_valid_o)); // R10
endmodule

// File: tb/vec_elem_seq_tb_top.sv
module vec_elem_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [6:0]  vl_i;
    logic [6:0]  rt_base_i, ra_base_i, rb_base_i;
    logic        rt_vec_i, ra_vec_i, rb_vec_i;
    logic        pred_en_i;
    logic [63:0] pred_mask_i;
    logic        issue_ready_i;
    logic        issue_valid_o;
    logic [5:0]  elem_o;
    logic [6:0]  rd_idx_o, rs1_idx_o, rs2_idx_o;
    logic        busy_o, done_o, err_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    vec_elem_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i),
        .rt_base_i(rt_base_i), .ra_base_i(ra_base_i), .rb_base_i(rb_base_i),
        .rt_vec_i(rt_vec_i), .ra_vec_i(ra_vec_i), .rb_vec_i(rb_vec_i),
        .pred_en_i(pred_en_i), .pred_mask_i(pred_mask_i),
        .issue_ready_i(issue_ready_i), .issue_valid_o(issue_valid_o),
        .elem_o(elem_o), .rd_idx_o(rd_idx_o), .rs1_idx_o(rs1_idx_o),
        .rs2_idx_o(rs2_idx_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_error(int vl, int rt, int ra, int rb, bit tv, bit av, bit bv);
        if (vl > 64) return 1'b1;
        if (vl == 0) return 1'b0;
        return (tv && rt + vl - 1 > 127) || (av && ra + vl - 1 > 127) || (bv && rb + vl - 1 > 127);
    endfunction

    function automatic int vidx(int base, bit v, int e);
        return v ? base + e : base;
    endfunction

    task automatic run_op(input int vl, input int rt, input int ra, input int rb,
                          input bit tv, input bit av, input bit bv,
                          input bit pen, input logic [63:0] mask,
                          input int ready_pct, input bit poke);
        int  exp_el[64];
        int  n_exp = 0;
        int  k = 0;
        int  cyc = 0;
        bit  err_exp;
        bit  stall = 1'b0;
        logic [6:0] p_rd = '0, p_s1 = '0, p_s2 = '0;
        logic [5:0] p_el = '0;
        logic [63:0] eff;
        err_exp = exp_error(vl, rt, ra, rb, tv, av, bv);
        eff = pen ? mask : '1;
        if (!err_exp) begin
            for (int i = 0; i < vl; i++) begin
                if (eff[i]) begin
                    exp_el[n_exp] = i;
                    n_exp++;
                    if (!tv) break;
                end
            end
        end
        start_i = 1'b1; vl_i = 7'(vl);
        rt_base_i = 7'(rt); ra_base_i = 7'(ra); rb_base_i = 7'(rb);
        rt_vec_i = tv; ra_vec_i = av; rb_vec_i = bv;
        pred_en_i = pen; pred_mask_i = mask; issue_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            if (done_o) break;
            chk(busy_o, "R8", "busy during sequence", busy_o, 1);
            if (issue_valid_o) begin
                if (k >= n_exp) begin
                    chk(1'b0, "R6", "unexpected extra issue", elem_o, -1);
                end else begin
                    chk(elem_o == exp_el[k], "R3 R5", "element number", elem_o, exp_el[k]);
                    chk(rd_idx_o == vidx(rt, tv, exp_el[k]), "R4", "rd index", rd_idx_o, vidx(rt, tv, exp_el[k]));
                    chk(rs1_idx_o == vidx(ra, av, exp_el[k]), "R4", "rs1 index", rs1_idx_o, vidx(ra, av, exp_el[k]));
                    chk(rs2_idx_o == vidx(rb, bv, exp_el[k]), "R4", "rs2 index", rs2_idx_o, vidx(rb, bv, exp_el[k]));
                end
            end
            if (stall) begin
                chk(issue_valid_o && elem_o == p_el && rd_idx_o == p_rd && rs1_idx_o == p_s1
                    && rs2_idx_o == p_s2, "R7", "offer held across stall", elem_o, p_el);
            end
            issue_ready_i = ($urandom_range(99) < ready_pct);
            stall = issue_valid_o && !issue_ready_i;
            p_el = elem_o; p_rd = rd_idx_o; p_s1 = rs1_idx_o; p_s2 = rs2_idx_o;
            if (issue_valid_o && issue_ready_i) k++;
            if (poke && cyc == 1) begin
                start_i = 1'b1; vl_i = 7'd3; rt_vec_i = ~tv; ra_vec_i = ~av;
                rt_base_i = 7'd1; ra_base_i = 7'd2; rb_base_i = 7'd3;
                pred_en_i = 1'b1; pred_mask_i = 64'h5;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 400) begin
                chk(1'b0, "R9", "sequence never completed", cyc, 0);
                break;
            end
        end
        start_i = 1'b0;
        issue_ready_i = 1'b0;
        chk(k == n_exp, "R6 R9", "issued element count", k, n_exp);
        chk(err_o == err_exp, "R10", "error flag at done", err_o, err_exp);
        @(negedge clk);
        chk(!done_o, "R9", "done is a single pulse", done_o, 0);
        chk(!busy_o, "R8", "busy low after done", busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; vl_i = '0;
        rt_base_i = '0; ra_base_i = '0; rb_base_i = '0;
        rt_vec_i = 1'b0; ra_vec_i = 1'b0; rb_vec_i = 1'b0;
        pred_en_i = 1'b0; pred_mask_i = '0; issue_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o, "R1", "busy after reset", busy_o, 0);
        chk(!issue_valid_o, "R1", "valid after reset", issue_valid_o, 0);
        chk(!done_o && !err_o, "R1", "done/err after reset", done_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o, "R8", "idle without start", busy_o, 0);

        // directed corners
        run_op(8, 10, 20, 30, 1, 1, 1, 0, 64'h0, 100, 0);          // R5 absent predicate
        run_op(0, 10, 20, 30, 1, 1, 1, 0, 64'h0, 100, 0);          // R9 empty
        run_op(8, 10, 20, 30, 1, 1, 0, 1, 64'h0, 100, 0);          // R9 all masked
        run_op(1, 5, 6, 7, 0, 0, 0, 0, 64'h0, 100, 0);             // scalar VL=1
        run_op(64, 64, 64, 0, 1, 1, 0, 1, {32'hA5A5_0F0F, 32'h1234_8001}, 60, 0); // R10 edge legal
        run_op(64, 65, 0, 0, 1, 0, 0, 0, 64'h0, 100, 0);           // R10 dest overflow
        run_op(65, 0, 0, 0, 0, 0, 0, 0, 64'h0, 100, 0);            // R10 VL>64
        run_op(20, 4, 110, 40, 1, 1, 0, 0, 64'h0, 100, 0);         // R10 source overflow
        run_op(16, 9, 30, 50, 0, 1, 1, 1, 64'h4, 50, 0);           // R6 scalar dest first issued
        run_op(64, 120, 3, 4, 0, 0, 0, 0, 64'h0, 100, 0);          // R6 scalar ops, high base
        run_op(10, 0, 40, 80, 1, 0, 1, 1, 64'h3F5, 30, 1);         // R2 start ignored while busy

        for (int t = 0; t < 60; t++) begin
            int vl;
            int rt, ra, rb;
            logic [63:0] m;
            vl = ($urandom_range(9) == 0) ? 65 + $urandom_range(62) : $urandom_range(64);
            rt = ($urandom_range(3) == 0) ? $urandom_range(127) : $urandom_range(63);
            ra = ($urandom_range(3) == 0) ? $urandom_range(127) : $urandom_range(63);
            rb = ($urandom_range(3) == 0) ? $urandom_range(127) : $urandom_range(63);
            m = {$urandom(), $urandom()};
            run_op(vl, rt, ra, rb, 1'($urandom_range(3) != 0), 1'($urandom_range(1)),
                   1'($urandom_range(1)), 1'($urandom_range(1)), m,
                   20 + $urandom_range(80), 1'($urandom_range(7) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule